// File: doc/BRIEF.md
# IDLE-Aligned 32-bit Word Assembler

This block sits behind the character decoder on the receive side of a 16-bit serial link. It rebuilds 32-bit words that the sender splits into two 16-bit halves sent back to back. The link carries no explicit framing for these halves. The word boundary is learned instead from IDLE characters: any IDLE ends a word. Once one IDLE has been seen, the block pairs halves continuously, so an unbroken stream of 32-bit words needs no further IDLEs.

A character is present on a cycle when `in_valid` is high, and `in_idle` tells an IDLE from a data half. Cycles with `in_valid` low carry nothing.

The controller has three states:
- `ALIGN_HUNT` is the reset state. In it the boundary is unknown and data halves are dropped. An IDLE moves the controller to `EXPECT_UPPER`.
- `EXPECT_UPPER` waits for a first half. A data half is held as the upper 16 bits, and the controller moves to `EXPECT_LOWER`. An IDLE keeps it in `EXPECT_UPPER`.
- `EXPECT_LOWER` waits for a second half. A data half completes the word, pulses `out_valid` and returns the controller to `EXPECT_UPPER`. An IDLE here drops the held half, pulses `framing_error` and also returns the controller to `EXPECT_UPPER`.

Top module: `word_pair_assembler`

## Requirements
- R1: During and right after reset, `out_valid` and `framing_error` are 0, `out_word` is 0, and the block is unaligned.
- R2: Before the first IDLE after reset, data halves are discarded, so `out_valid` stays 0 however many halves arrive.
- R3: After an IDLE, the next data half becomes bits [31:16] and the following data half becomes bits [15:0]. On the clock edge that samples the second half, `out_word` is loaded and `out_valid` is high for the cycle after that edge.
- R4: After alignment, back-to-back halves with no IDLEs keep alternating between first and second halves. Each `out_valid` pulse lasts exactly one cycle.
- R5: An IDLE arriving between a first half and its second half discards the held half. It raises `framing_error` for exactly one cycle, and the next data half is treated as a first half.
- R6: An IDLE arriving while a first half is expected, including several IDLEs in a row, raises no `framing_error` and keeps the alignment.
- R7: A cycle with `in_valid` low has no effect on the alignment or on the held half, whatever `in_data` and `in_idle` carry.
- R8: `out_word` keeps its last value in every cycle where `out_valid` is 0.
- R9: `out_valid` and `framing_error` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | HALF_W (16) | Decoded data half |
| in_valid | input | 1 | A character is present this cycle |
| in_idle | input | 1 | The present character is an IDLE (1) or a data half (0) |
| out_word | output | 2*HALF_W (32) | Assembled word, with the first half in the upper bits |
| out_valid | output | 1 | One-cycle pulse when `out_word` has just been loaded |
| framing_error | output | 1 | One-cycle pulse when a partial word has been dropped |

## Verification
Two things can land in the same cycle. The first is the output pulse of a completed word, together with the capture of the next word's first half. The bench provokes this by sending halves back to back with no gap, then judges that the pulse stays one cycle long and that `out_word` is not disturbed by the new upper half. The second is the `framing_error` pulse, together with the capture of a fresh first half right after the offending IDLE. The bench checks that this half is correctly paired with the one that follows it. A behavioural reference model built on a queue of halves is compared with all three outputs on every clock.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    typedef enum logic [1:0] {
        ALIGN_HUNT   = 2'd0,
        EXPECT_UPPER = 2'd1,
        EXPECT_LOWER = 2'd2
    } align_state_e;

endpackage

// File: rtl/wpa_align_fsm.sv
module wpa_align_fsm
    import wpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic char_valid,
    input  logic char_idle,
    output logic take_upper,
    output logic take_lower,
    output logic drop_partial
);

    align_state_e state_q;
    align_state_e state_d;

    logic data_seen;
    logic idle_seen;

    assign data_seen = char_valid && !char_idle;
    assign idle_seen = char_valid &&  char_idle;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALIGN_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALIGN_HUNT: begin
                if (idle_seen) state_d = EXPECT_UPPER;
            end
            EXPECT_UPPER: begin
                if (data_seen) state_d = EXPECT_LOWER;
            end
            EXPECT_LOWER: begin
                if (data_seen || idle_seen) state_d = EXPECT_UPPER;
            end
            default: state_d = ALIGN_HUNT;
        endcase
    end

    // Strobes toward the datapath
    always_comb begin
        take_upper   = 1'b0;
        take_lower   = 1'b0;
        drop_partial = 1'b0;
        unique case (state_q)
            ALIGN_HUNT: begin
            end
            EXPECT_UPPER: begin
                take_upper = data_seen;
            end
            EXPECT_LOWER: begin
                take_lower   = data_seen;
                drop_partial = idle_seen;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/wpa_word_join.sv
module wpa_word_join #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     half_in,
    input  logic                  take_upper,
    input  logic                  take_lower,
    input  logic                  drop_partial,
    output logic [2*HALF_W-1:0]   word_out,
    output logic                  word_valid,
    output logic                  frame_err
);

    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] upper_q;
    logic [WORD_W-1:0] word_q;
    logic              valid_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
        end else if (take_upper) begin
            upper_q <= half_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= take_lower;
            err_q   <= drop_partial;
            if (take_lower) begin
                word_q <= {upper_q, half_in};
            end
        end
    end

    assign word_out   = word_q;
    assign word_valid = valid_q;
    assign frame_err  = err_q;

endmodule

// File: rtl/word_pair_assembler.sv
module word_pair_assembler #(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     in_data,
    input  logic                  in_valid,
    input  logic                  in_idle,
    output logic [2*HALF_W-1:0]   out_word,
    output logic                  out_valid,
    output logic                  framing_error
);

    logic take_upper;
    logic take_lower;
    logic drop_partial;

    wpa_align_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_valid   (in_valid),
        .char_idle    (in_idle),
        .take_upper   (take_upper),
        .take_lower   (take_lower),
        .drop_partial (drop_partial)
    );

    wpa_word_join #(.HALF_W(HALF_W)) u_join (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_in      (in_data),
        .take_upper   (take_upper),
        .take_lower   (take_lower),
        .drop_partial (drop_partial),
        .word_out     (out_word),
        .word_valid   (out_valid),
        .frame_err    (framing_error)
    );

endmodule

// File: rtl/word_pair_assembler_chk.sv
module word_pair_assembler_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_idle,
    input logic [2*HALF_W-1:0] out_word,
    input logic                out_valid,
    input logic                framing_error
);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && framing_error));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        framing_error |=> !framing_error);

    p_err_after_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(framing_error) |-> $past(in_valid && in_idle));

    p_valid_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && !in_idle));

    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_word));

endmodule

bind word_pair_assembler word_pair_assembler_chk #(.HALF_W(HALF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_idle       (in_idle),
    .out_word      (out_word),
    .out_valid     (out_valid),
    .framing_error (framing_error)
);

// File: tb/word_pair_assembler_bench.sv
module word_pair_assembler_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_idle = 1'b0;
    logic [31:0] out_word;
    logic        out_valid;
    logic        framing_error;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #10 clk = ~clk;

    word_pair_assembler u_word_pair_assembler (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_idle       (in_idle),
        .out_word      (out_word),
        .out_valid     (out_valid),
        .framing_error (framing_error)
    );

    // Reference model: a queue of pending halves plus an alignment flag
    logic [15:0] pend[$];
    bit          m_aligned = 1'b0;
    logic        exp_v = 1'b0;
    logic        exp_e = 1'b0;
    logic [31:0] exp_w = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pend.delete();
            m_aligned = 1'b0;
            exp_v = 1'b0;
            exp_e = 1'b0;
            exp_w = '0;
        end else begin
            exp_v = 1'b0;
            exp_e = 1'b0;
            if (in_valid) begin
                if (in_idle) begin
                    if (pend.size() != 0) exp_e = 1'b1;
                    pend.delete();
                    m_aligned = 1'b1;
                end else if (m_aligned) begin
                    pend.push_back(in_data);
                    if (pend.size() == 2) begin
                        exp_w = {pend[0], pend[1]};
                        exp_v = 1'b1;
                        pend.delete();
                    end
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare with the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk({cur_req, " out_valid"}, {31'd0, out_valid}, {31'd0, exp_v});
            chk({cur_req, " framing_error"}, {31'd0, framing_error}, {31'd0, exp_e});
            chk({cur_req, " out_word"}, out_word, exp_w);
            chk("R9 exclusive pulses", {31'd0, out_valid && framing_error}, 32'd0);
        end
    end

    task automatic send(input logic v, input logic idle, input logic [15:0] d);
        in_valid = v;
        in_idle  = idle;
        in_data  = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 reset framing_error", {31'd0, framing_error}, 32'd0);
        chk("R1 reset out_word", out_word, 32'd0);
        rst_n = 1'b1;

        cur_req = "R2";
        send(1, 0, 16'h1111);
        send(1, 0, 16'h2222);
        chk("R2 discard before idle", {31'd0, out_valid}, 32'd0);
        send(1, 0, 16'h3333);
        chk("R2 discard before idle", {31'd0, out_valid}, 32'd0);

        cur_req = "R3";
        send(1, 1, 16'h0000);
        send(1, 0, 16'hA1B2);
        send(1, 0, 16'hC3D4);
        chk("R3 pulse", {31'd0, out_valid}, 32'd1);
        chk("R3 word order", out_word, 32'hA1B2C3D4);

        cur_req = "R4";
        send(1, 0, 16'h0001);
        chk("R4 single-cycle pulse", {31'd0, out_valid}, 32'd0);
        chk("R4 word undisturbed by new upper", out_word, 32'hA1B2C3D4);
        send(1, 0, 16'h0002);
        chk("R4 second word", out_word, 32'h00010002);
        send(1, 0, 16'h0003);
        send(1, 0, 16'h0004);
        chk("R4 third word", out_word, 32'h00030004);

        cur_req = "R5";
        send(1, 0, 16'h5555);
        send(1, 1, 16'h0000);
        chk("R5 error pulse", {31'd0, framing_error}, 32'd1);
        send(1, 0, 16'h6666);
        chk("R5 error one cycle", {31'd0, framing_error}, 32'd0);
        send(1, 0, 16'h7777);
        chk("R5 realigned word", out_word, 32'h66667777);

        cur_req = "R6";
        send(1, 1, 16'h0000);
        send(1, 1, 16'h0000);
        send(1, 1, 16'h0000);
        chk("R6 no error on idle", {31'd0, framing_error}, 32'd0);
        send(1, 0, 16'h8888);
        send(1, 0, 16'h9999);
        chk("R6 word after idles", out_word, 32'h88889999);

        cur_req = "R7";
        send(1, 0, 16'hAAAA);
        send(0, 1, 16'hFFFF);
        chk("R7 gap no error", {31'd0, framing_error}, 32'd0);
        send(0, 0, 16'hEEEE);
        chk("R7 gap no word", {31'd0, out_valid}, 32'd0);
        send(1, 0, 16'hBBBB);
        chk("R7 word across gaps", out_word, 32'hAAAABBBB);

        cur_req = "R8";
        send(0, 0, 16'h1234);
        send(0, 1, 16'h5678);
        chk("R8 word held", out_word, 32'hAAAABBBB);
        chk("R8 no pulse", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule